// File: doc/BRIEF.md
# Demagnetization Time Compensation Unit

This block corrects a measured secondary conduction time before a charge regulation loop uses it. A ringing-edge time, measured at the zero-current detector, is scaled by a programmable fixed-point gain. The scaled value is then taken away from the conduction time. Flyback designs need this because the detector fires late by a part of one ringing period.

The two measurements arrive as clock counts, and each has its own valid strobe. They may come in the same cycle or in different cycles. A measurement that arrives first is held until its partner comes. When the pair is complete, the block samples it together with the gain code and the compensation enable. The pair then goes through a three-register pipeline. The block can accept a new pair on every cycle. When compensation is off, the conduction time passes through unchanged.

Top module: `t2_comp_unit`

## Requirements
- R1: While `rstN` is low, and after its release until the first pair completes, `outValid` is 0.
- R2: A pair completes in the cycle in which both measurements are available. Each one is either strobed in that cycle or held from an earlier strobe. A measurement whose partner has not yet come is held, not dropped.
- R3: If a measurement is strobed again while it is still waiting for its partner, the newer value replaces the held one. This includes the cycle in which the partner arrives.
- R4: For each completed pair, `outValid` is high for exactly one cycle. That cycle follows the third rising edge after the pair's completing cycle, so the output is ready two cycles after the edge that captures the pair. `outValid` is never high otherwise. Pairs may complete on consecutive cycles.
- R5: With `compEn` = 0 at completion, `outCount` equals the measured conduction time.
- R6: With `compEn` = 1, `outCount` = t2 − floor(ring × gainCode / 16). The 6-bit unsigned gain code gives 1/16 per step. The product is kept at full width before the right shift by 4.
- R7: With `compEn` = 1, if the scaled term is greater than or equal to t2, `outCount` is 0 and does not wrap.
- R8: `gainCode` and `compEn` are sampled in the completing cycle. Later changes do not affect a result in flight.
- R9: The largest code, 63, gives an effective gain of 63/16 (just below 4.0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| t2Count | input | CNT_W | Measured conduction time in clocks |
| t2Valid | input | 1 | Strobe for `t2Count` |
| ringCount | input | CNT_W | Measured ringing-edge time in clocks |
| ringValid | input | 1 | Strobe for `ringCount` |
| gainCode | input | 6 | Compensation gain, code/16 |
| compEn | input | 1 | 1 = subtract the scaled term |
| outCount | output | CNT_W | Compensated conduction time |
| outValid | output | 1 | One-cycle strobe for `outCount` |

## Verification
Two events can fall in the same cycle: a held measurement being replaced by a new strobe, and its partner arriving to complete the pair. The bench provokes this by holding a ringing time, then strobing a new ringing time together with the conduction time. It judges the result by which ringing value shows up in the compensated output. Pair completion can also coincide with a changing gain code. The bench checks this by holding the conduction time under one code and completing the pair under another. The completing cycle's code must be the one that appears in the result.

// File: rtl/t2_comp_pkg.sv
package t2_comp_pkg;
  typedef struct packed {
    logic holdT2;     // store incoming t2 as pending
    logic holdRing;   // store incoming ring as pending
    logic selNewT2;   // completing pair takes t2 from the port
    logic selNewRing; // completing pair takes ring from the port
    logic fire;       // pair completes this cycle
    logic adv1;       // stage 1 holds a live pair
    logic adv2;       // stage 2 holds a live pair
  } ctrlStrobes_t;
endpackage

// File: rtl/t2_comp_ctrl.sv
module t2_comp_ctrl
  import t2_comp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         t2Valid,
  input  logic         ringValid,
  output ctrlStrobes_t strb,
  output logic         outValid
);
  logic pendT2, pendRing, live1, live2, fireNow;

  assign fireNow = (t2Valid | pendT2) & (ringValid | pendRing);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendT2   <= 1'b0;
      pendRing <= 1'b0;
      live1    <= 1'b0;
      live2    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      pendT2   <= fireNow ? 1'b0 : (pendT2 | t2Valid);
      pendRing <= fireNow ? 1'b0 : (pendRing | ringValid);
      live1    <= fireNow;
      live2    <= live1;
      outValid <= live2;
    end
  end

  always_comb begin
    strb.holdT2     = t2Valid & ~fireNow;
    strb.holdRing   = ringValid & ~fireNow;
    strb.selNewT2   = t2Valid;
    strb.selNewRing = ringValid;
    strb.fire       = fireNow;
    strb.adv1       = live1;
    strb.adv2       = live2;
  end
endmodule

// File: rtl/t2_comp_dp.sv
module t2_comp_dp
  import t2_comp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GAIN_W = 6,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [CNT_W-1:0]  t2Count,
  input  logic [CNT_W-1:0]  ringCount,
  input  logic [GAIN_W-1:0] gainCode,
  input  logic              compEn,
  output logic [CNT_W-1:0]  outCount
);
  localparam int PROD_W = CNT_W + GAIN_W;
  localparam int SCL_W  = PROD_W - FRAC_W;

  logic [CNT_W-1:0]  t2Held, ringHeld;
  logic [CNT_W-1:0]  s1T2, s1Ring, s2T2;
  logic [GAIN_W-1:0] s1Gain;
  logic              s1En, s2En;
  logic [PROD_W-1:0] prodFull;
  logic [SCL_W-1:0]  s2Scaled, diffWide;
  logic [CNT_W-1:0]  resultNext;

  assign prodFull = PROD_W'(s1Ring) * PROD_W'(s1Gain);
  assign diffWide = SCL_W'(s2T2) - s2Scaled;

  always_comb begin
    if (!s2En)                        resultNext = s2T2;
    else if (s2Scaled >= SCL_W'(s2T2)) resultNext = '0;
    else                              resultNext = diffWide[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t2Held   <= '0;
      ringHeld <= '0;
      s1T2     <= '0;
      s1Ring   <= '0;
      s1Gain   <= '0;
      s1En     <= 1'b0;
      s2T2     <= '0;
      s2Scaled <= '0;
      s2En     <= 1'b0;
      outCount <= '0;
    end else begin
      if (strb.holdT2)   t2Held   <= t2Count;
      if (strb.holdRing) ringHeld <= ringCount;
      if (strb.fire) begin
        s1T2   <= strb.selNewT2   ? t2Count   : t2Held;
        s1Ring <= strb.selNewRing ? ringCount : ringHeld;
        s1Gain <= gainCode;
        s1En   <= compEn;
      end
      if (strb.adv1) begin
        s2T2     <= s1T2;
        s2Scaled <= prodFull[PROD_W-1:FRAC_W];
        s2En     <= s1En;
      end
      if (strb.adv2) outCount <= resultNext;
    end
  end
endmodule

// File: rtl/t2_comp_unit.sv
module t2_comp_unit
  import t2_comp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GAIN_W = 6,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  t2Count,
  input  logic              t2Valid,
  input  logic [CNT_W-1:0]  ringCount,
  input  logic              ringValid,
  input  logic [GAIN_W-1:0] gainCode,
  input  logic              compEn,
  output logic [CNT_W-1:0]  outCount,
  output logic              outValid
);
  ctrlStrobes_t strb;
  logic         pairFire;

  assign pairFire = strb.fire;

  t2_comp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .t2Valid(t2Valid), .ringValid(ringValid),
    .strb(strb), .outValid(outValid)
  );

  t2_comp_dp #(.CNT_W(CNT_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .t2Count(t2Count),
    .ringCount(ringCount), .gainCode(gainCode), .compEn(compEn),
    .outCount(outCount)
  );
endmodule

// File: rtl/t2_comp_checks.sv
module t2_comp_checks #(
  parameter int CNT_W  = 16,
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              pairFire,
  input logic              t2Valid,
  input logic [CNT_W-1:0]  t2Count,
  input logic [GAIN_W-1:0] gainCode,
  input logic              compEn,
  input logic [CNT_W-1:0]  outCount,
  input logic              outValid
);
  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairFire |=> ##2 outValid);
  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pairFire, 3));
  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairFire && t2Valid && !compEn) |=> ##2 (outCount == $past(t2Count, 3)));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairFire && t2Valid) |=> ##2 (outCount <= $past(t2Count, 3)));
  // R6
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairFire && t2Valid && gainCode == '0) |=> ##2 (outCount == $past(t2Count, 3)));
endmodule

bind t2_comp_unit t2_comp_checks #(.CNT_W(CNT_W), .GAIN_W(GAIN_W)) u_checks (
  .clk(clk), .rstN(rstN), .pairFire(pairFire), .t2Valid(t2Valid),
  .t2Count(t2Count), .gainCode(gainCode), .compEn(compEn),
  .outCount(outCount), .outValid(outValid)
);

// File: tb/test_t2_comp_unit.sv
`timescale 1ns/1ps
module test_t2_comp_unit;
  localparam int CNT_W = 16;
  localparam int MAXK  = 4000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] t2Count = '0;
  logic             t2Valid = 1'b0;
  logic [CNT_W-1:0] ringCount = '0;
  logic             ringValid = 1'b0;
  logic [5:0]       gainCode = '0;
  logic             compEn = 1'b0;
  logic [CNT_W-1:0] outCount;
  logic             outValid;

  int vectors = 0, miscompares = 0, k = 0;
  bit done = 0;
  bit    expV [MAXK+8];
  int    expC [MAXK+8];
  string expTag [MAXK+8];
  bit pT2 = 0, pR = 0;
  int pT2v = 0, pRv = 0;

  always #10 clk = ~clk;

  t2_comp_unit i_t2_comp_unit (
    .clk(clk), .rstN(rstN), .t2Count(t2Count), .t2Valid(t2Valid),
    .ringCount(ringCount), .ringValid(ringValid), .gainCode(gainCode),
    .compEn(compEn), .outCount(outCount), .outValid(outValid)
  );

  function automatic int refOut(int t, int r, int g, bit e);
    longint scaled = (longint'(r) * g) >>> 4;
    if (!e) return t;
    if (scaled >= t) return 0;
    return t - int'(scaled);
  endfunction

  task automatic checkNow();
    vectors++;
    if (outValid !== expV[k]) begin
      miscompares++;
      $display("FAIL %s k=%0d outValid actual=%b expected=%b", expTag[k], k, outValid, expV[k]);
    end else if (expV[k] && int'(outCount) != expC[k]) begin
      miscompares++;
      $display("FAIL %s k=%0d outCount actual=%0d expected=%0d", expTag[k], k, outCount, expC[k]);
    end
  endtask

  task automatic step(bit tv, int t, bit rv, int r, int g, bit e, string tag);
    int tu, ru;
    @(negedge clk);
    checkNow();
    t2Valid = tv; t2Count = CNT_W'(t); ringValid = rv; ringCount = CNT_W'(r);
    gainCode = 6'(g); compEn = e;
    if ((tv || pT2) && (rv || pR)) begin
      tu = tv ? t : pT2v;
      ru = rv ? r : pRv;
      expV[k+3] = 1; expC[k+3] = refOut(tu, ru, g, e); expTag[k+3] = tag;
      pT2 = 0; pR = 0;
    end else begin
      if (tv) begin pT2 = 1; pT2v = t; end
      if (rv) begin pR = 1; pRv = r; end
    end
    k++;
  endtask

  initial begin
    for (int i = 0; i < MAXK + 8; i++) begin expV[i] = 0; expC[i] = 0; expTag[i] = "R4"; end
    expTag[0] = "R1"; expTag[1] = "R1"; expTag[2] = "R1"; expTag[3] = "R1";
    repeat (3) begin
      @(negedge clk);
      vectors++;
      if (outValid !== 1'b0) begin
        miscompares++;
        $display("FAIL R1 in reset outValid actual=%b expected=0", outValid);
      end
    end
    rstN = 1'b1;
    // R6 basic, both strobes together
    step(1, 1000, 1, 100, 16, 1, "R6");
    step(1, 1000, 1, 100, 0, 1, "R6");
    // R9 top code
    step(1, 2000, 1, 160, 63, 1, "R9");
    // R6 truncation of fractional product
    step(1, 5, 1, 1, 15, 1, "R6");
    // R7 equality and overshoot saturate to zero
    step(1, 16, 1, 16, 16, 1, "R7");
    step(1, 16, 1, 17, 16, 1, "R7");
    step(1, 3, 1, 65535, 63, 1, "R7");
    // R5 bypass
    step(1, 10, 1, 1000, 63, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R4");
    // R2 separate arrival, t2 first then ring
    step(1, 4000, 0, 0, 0, 1, "R2");
    step(0, 0, 0, 0, 0, 1, "R2");
    step(0, 0, 1, 320, 8, 1, "R2");
    // R2 ring first
    step(0, 0, 1, 64, 0, 1, "R2");
    step(1, 900, 0, 0, 32, 1, "R2");
    // R3 replacement of pending t2
    step(1, 500, 0, 0, 0, 1, "R3");
    step(1, 700, 0, 0, 0, 1, "R3");
    step(0, 0, 1, 0, 16, 1, "R3");
    // R3 replacement coinciding with completion
    step(0, 0, 1, 50, 0, 1, "R3");
    step(1, 3000, 1, 800, 16, 1, "R3");
    // R8 gain/enable taken at completion, then changed in flight
    step(1, 6000, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 480, 32, 1, "R8");
    step(0, 0, 0, 0, 63, 0, "R8");
    step(0, 0, 0, 0, 5, 1, "R8");
    // R4 back-to-back random traffic
    repeat (2500) begin
      bit tv = ($urandom_range(0, 3) != 0);
      bit rv = ($urandom_range(0, 3) != 0);
      int t = $urandom_range(0, 65535);
      int r = $urandom_range(0, 7) == 0 ? $urandom_range(0, 65535) : $urandom_range(0, 4000);
      int g = $urandom_range(0, 63);
      bit e = ($urandom_range(0, 4) != 0);
      step(tv, t, rv, r, g, e, e ? "R6" : "R5");
    end
    repeat (4) step(0, 0, 0, 0, 0, 0, "R4");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule